// File: doc/BRIEF.md
# Bounded-Delay Pipeline Stage Controller

This block is a clocked model of the control for one stage of a self-timed pipeline. The computation in the stage sits outside the block. It is plain combinational logic with a known worst-case latency. The controller feeds that logic from its input register and takes the result back into its output register. It does not watch for a completion signal. Instead, it trusts a delay element sized to the stage's worst case. That element is a down-counter, loaded with a bound in clock cycles when new data is taken in. When the counter runs out, the result is latched and offered downstream.

Both edges of the stage use a four-phase request/acknowledge protocol, and neither side of it relies on timing estimates. The stage takes a new operand only while its output register is empty. It acknowledges upstream only after the result has been latched. The output register counts as free once the downstream receiver has finished its full return-to-zero cycle. The worst-case bound is supplied per stage through `boundCycles` and is sampled at capture.

Top module: `bdelay_stage`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `inAck` and `outReq` low, clears `opData` and `outData` to zero and marks the output register empty.
- R2: While the stage is idle with an empty output register, `inReq` sampled high at an edge captures `inData`. `opData` shows the captured word from that edge on and keeps it until the next capture.
- R3: `boundCycles` (value B) is sampled at the capture edge. At capture edge + B, `resData` is latched into `outData` and `outReq` rises. A bound of zero behaves as one.
- R4: `inAck` stays low from the capture edge until the latch edge and rises at the same edge as `outReq`.
- R5: `inAck` stays high while `inReq` is high. It falls at the first edge that samples `inReq` low.
- R6: `outReq` stays high and `outData` holds still until an edge samples `outAck` high. `outReq` falls at that edge.
- R7: The output register becomes free at the edge that samples `outAck` low after the downstream acknowledge. The earliest capture is the edge after that. Until then, a waiting `inReq` is not acknowledged and `opData` keeps the previous operand.
- R8: Changes to `inData` and `boundCycles` after the capture edge alter neither the latched result nor its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inReq | input | 1 | Upstream request: `inData` is valid |
| inData | input | DATA_W | Upstream operand |
| boundCycles | input | BOUND_W | Worst-case latency of the stage logic in cycles (0 acts as 1) |
| inAck | output | 1 | Upstream acknowledge |
| opData | output | DATA_W | Held operand driving the external stage logic |
| resData | input | DATA_W | Result from the external stage logic |
| outReq | output | 1 | Downstream request: `outData` is valid |
| outData | output | DATA_W | Output register contents |
| outAck | input | 1 | Downstream acknowledge |

## Verification
Each result is due B cycles after its capture edge, and both `inAck` and `outReq` rise on that same edge. The capture edge is either the edge after `inReq` is raised or, when the receiver is still holding, the second edge after the receiver drops `outAck`. The bench works out each due edge from the time it raised `inReq` and from the receiver's own release time. It queues the expected word with that edge number. The receiver process compares against it at the first falling edge on which `outReq` is visible. The handshake and hold checks are made one falling edge after the rising edge that should cause them, so every sample falls in a settled half-cycle.

// File: rtl/bds_pkg.sv
package bds_pkg;

  typedef enum logic [1:0] {
    UP_IDLE = 2'd0,
    UP_CALC = 2'd1,
    UP_ACK  = 2'd2
  } upState_t;

  typedef enum logic [1:0] {
    DN_EMPTY   = 2'd0,
    DN_OFFER   = 2'd1,
    DN_RELEASE = 2'd2
  } dnState_t;

  typedef struct packed {
    logic captureEn;
    logic latchEn;
  } strobe_t;

endpackage

// File: rtl/bds_delay.sv
module bds_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (loadVal == '0) ? ONE : loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign expire = (cnt == ONE);

  // R3: the delay element fires once per load
  p_single_fire_r3: assert property (@(posedge clk) disable iff (rst)
    expire && !load |=> !expire);

  // R3: an idle element stays silent until reloaded
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) && !load |=> !expire);

endmodule

// File: rtl/bds_ctrl.sv
module bds_ctrl
  import bds_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inReq,
  input  logic    outAck,
  input  logic    expire,
  output strobe_t strobe,
  output logic    inAck,
  output logic    outReq
);

  upState_t upState, upNext;
  dnState_t dnState, dnNext;

  always_comb begin
    upNext           = upState;
    strobe.captureEn = 1'b0;
    strobe.latchEn   = 1'b0;
    case (upState)
      UP_IDLE: begin
        if (inReq && (dnState == DN_EMPTY)) begin
          strobe.captureEn = 1'b1;
          upNext           = UP_CALC;
        end
      end
      UP_CALC: begin
        if (expire) begin
          strobe.latchEn = 1'b1;
          upNext         = UP_ACK;
        end
      end
      UP_ACK: begin
        if (!inReq) upNext = UP_IDLE;
      end
      default: upNext = UP_IDLE;
    endcase
  end

  always_comb begin
    dnNext = dnState;
    case (dnState)
      DN_EMPTY:   if (strobe.latchEn) dnNext = DN_OFFER;
      DN_OFFER:   if (outAck)         dnNext = DN_RELEASE;
      DN_RELEASE: if (!outAck)        dnNext = DN_EMPTY;
      default:                        dnNext = DN_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upState <= UP_IDLE;
      dnState <= DN_EMPTY;
    end else begin
      upState <= upNext;
      dnState <= dnNext;
    end
  end

  assign inAck  = (upState == UP_ACK);
  assign outReq = (dnState == DN_OFFER);

  // R4: upstream acknowledge appears together with the downstream offer
  p_ack_with_offer_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(inAck) |-> $rose(outReq));

  // R5: acknowledge released once the request is seen low
  p_ack_release_r5: assert property (@(posedge clk) disable iff (rst)
    inAck && !inReq |=> !inAck);

  // R6: offer held until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    outReq && !outAck |=> outReq);

  // R7: a capture never coincides with an occupied output
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.captureEn |=> !outReq && !inAck);

endmodule

// File: rtl/bds_dpath.sv
module bds_dpath
  import bds_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] resData,
  output logic [DATA_W-1:0] opData,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] inReg;
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      inReg  <= '0;
      outReg <= '0;
    end else begin
      if (strobe.captureEn) inReg  <= inData;
      if (strobe.latchEn)   outReg <= resData;
    end
  end

  assign opData  = inReg;
  assign outData = outReg;

  // R2: the operand and result registers never load on the same edge
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(strobe.captureEn && strobe.latchEn));

endmodule

// File: rtl/bdelay_stage.sv
module bdelay_stage
  import bds_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BOUND_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inReq,
  input  logic [DATA_W-1:0]  inData,
  input  logic [BOUND_W-1:0] boundCycles,
  output logic               inAck,
  output logic [DATA_W-1:0]  opData,
  input  logic [DATA_W-1:0]  resData,
  output logic               outReq,
  output logic [DATA_W-1:0]  outData,
  input  logic               outAck
);

  strobe_t strobe;
  logic    expire;

  bds_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .inReq  (inReq),
    .outAck (outAck),
    .expire (expire),
    .strobe (strobe),
    .inAck  (inAck),
    .outReq (outReq)
  );

  bds_delay #(.CNT_W(BOUND_W)) u_delay (
    .clk     (clk),
    .rst     (rst),
    .load    (strobe.captureEn),
    .loadVal (boundCycles),
    .expire  (expire)
  );

  bds_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inData  (inData),
    .resData (resData),
    .opData  (opData),
    .outData (outData)
  );

  // R6: offered data holds still until acknowledged
  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    outReq && !outAck |=> $stable(outData));

  // R1: reset leaves both handshakes quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !inAck && !outReq);

endmodule

// File: tb/bdelay_stage_bench.sv
`timescale 1ns/1ps
module bdelay_stage_bench;

  localparam int DW = 16;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inReq = 1'b0;
  logic [DW-1:0] inData = '0;
  logic [BW-1:0] boundCycles = '0;
  logic          inAck;
  logic [DW-1:0] opData;
  logic [DW-1:0] resData;
  logic          outReq;
  logic [DW-1:0] outData;
  logic          outAck = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit doneFlag = 0;

  int expData[$];
  int expDue[$];
  int rxDelay = 0;
  int rxHold = 0;
  bit rxBusy = 0;
  int rxFreeEdge = 0;
  logic [DW-1:0] lastData = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] stageFn(input logic [DW-1:0] x);
    return (x * 16'd3) ^ 16'h5A5A;
  endfunction

  assign resData = stageFn(opData);

  bdelay_stage #(.DATA_W(DW), .BOUND_W(BW)) u_bdelay_stage (
    .clk(clk), .rst(rst), .inReq(inReq), .inData(inData),
    .boundCycles(boundCycles), .inAck(inAck), .opData(opData),
    .resData(resData), .outReq(outReq), .outData(outData), .outAck(outAck)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: one item through the upstream handshake
  task automatic sendItem(input logic [DW-1:0] d, input logic [BW-1:0] b, input int holdAfter);
    int c, effB, due, capE;
    bit known;
    @(negedge clk);
    inData = d; boundCycles = b; inReq = 1'b1; c = cyc;
    effB = (b == 0) ? 1 : int'(b);
    known = 0; capE = 0; due = 0;
    while (1) begin
      if (!known && !rxBusy) begin
        capE = (c + 1 > rxFreeEdge) ? c + 1 : rxFreeEdge;
        due = capE + effB;
        expData.push_back(int'(stageFn(d)));
        expDue.push_back(due);
        known = 1;
      end
      if (inAck) break;
      if (!known || cyc < capE) begin
        check(opData == lastData, "R7 operand held while output busy", opData, lastData);
      end else begin
        check(opData == d, "R2 captured operand", opData, d);
        inData = ~d; boundCycles = 8'd1;   // R8 scramble after capture
      end
      @(negedge clk);
    end
    check(cyc == due, "R4 inAck at latch edge (R3 bound)", cyc, due);
    lastData = d;
    for (int i = 0; i < holdAfter; i++) begin
      @(negedge clk);
      check(inAck == 1'b1, "R5 inAck held while inReq high", inAck, 1);
    end
    inReq = 1'b0;
    @(negedge clk);
    check(inAck == 1'b0, "R5 inAck released", inAck, 0);
  endtask

  // monitor / downstream receiver
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && outReq && !outAck) begin
        logic [DW-1:0] held;
        rxBusy = 1;
        held = outData;
        if (expData.size() == 0) begin
          check(0, "R3 unexpected outReq", 1, 0);
        end else begin
          int ed, eu;
          ed = expData.pop_front();
          eu = expDue.pop_front();
          check(cyc == eu, "R3 outReq timing", cyc, eu);
          check(outData == ed[DW-1:0], "R3 R8 result word", outData, ed);
        end
        for (int i = 0; i < rxDelay; i++) begin
          @(negedge clk);
          check(outReq == 1'b1 && outData == held, "R6 offer held", outData, held);
        end
        outAck = 1'b1;
        @(negedge clk);
        check(outReq == 1'b0, "R6 outReq drop after ack", outReq, 0);
        for (int i = 0; i < rxHold; i++) @(negedge clk);
        outAck = 1'b0;
        rxFreeEdge = cyc + 2;
        rxBusy = 0;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == 20000) begin
      check(0, "watchdog expired", cyc, 0);
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(inAck == 1'b0, "R1 inAck after reset", inAck, 0);
    check(outReq == 1'b0, "R1 outReq after reset", outReq, 0);
    check(outData == '0, "R1 outData after reset", outData, 0);
    check(opData == '0, "R1 opData after reset", opData, 0);

    rxDelay = 0; rxHold = 0;
    sendItem(16'h1234, 8'd1, 0);
    sendItem(16'hABCD, 8'd0, 1);     // R3 zero bound acts as one
    sendItem(16'h5555, 8'd5, 2);
    sendItem(16'h0042, 8'd9, 0);

    rxDelay = 12; rxHold = 3;        // R7 stalled receiver
    sendItem(16'h0F0F, 8'd3, 0);
    sendItem(16'hF00D, 8'd2, 0);
    sendItem(16'hBEEF, 8'd20, 1);

    rxDelay = 0; rxHold = 0;
    sendItem(16'h0007, 8'd7, 0);     // R8 long bound, scrambled inputs
    sendItem(16'hFFFF, 8'd255, 0);

    while (expData.size() != 0 || rxBusy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(outReq == 1'b0 && inAck == 1'b0, "R6 R5 quiet at end", outReq, 0);
    finishRun();
  end

endmodule